// File: doc/BRIEF.md
# External Memory Write Strobe Timer

This block runs write cycles to an external static memory, such as an SRAM. A write request carries a chip-select number, an address and a data word, and arrives over a valid/ready handshake. The block then drives the address and data buses, an active-low write strobe and one active-low chip-select line per device. The position of each strobe inside the cycle is counted in whole clock cycles. Each chip select has its own timing set, made of a setup count and a pulse count for the write strobe, the same pair for its chip-select line, and one total cycle length that both strobes share. The hold of each strobe is therefore implied as cycle minus setup minus pulse, so the two strobes always span the same total cycle.

The handshake follows these rules. `req_ready` is high while the block is idle and during the final count of a running cycle. A request is taken on any rising edge that sees `req_valid` and `req_ready` both high. Holding `req_valid` low simply leaves the block idle. No request is taken while `req_ready` is low, and the requester keeps its fields until a request is taken. A request taken in the final count starts its own count 0 on the very next clock. As a result, a strobe with zero setup and zero hold stays low across back-to-back writes to the same device.

Before a cycle starts, the timing set of the selected device is checked. A zero pulse, a cycle shorter than setup plus pulse, or zero setup together with zero hold on a device marked as latching data on the strobe's rising edge, makes the block consume the request and raise `cfg_err` instead of running the cycle.

Top module: `swt_write_timer`

## Requirements
- R1: After reset no cycle runs: `mem_we_n` is 1, every bit of `mem_cs_n` is 1, `wr_done` and `cfg_err` are 0, and `req_ready` is 1.
- R2: A request is taken on a rising edge with `req_valid` and `req_ready` high. `req_ready` is 1 when idle and in the final count, and 0 in every other count of a running cycle. The taken address and data appear on `mem_addr` and `mem_data` from count 0 and stay unchanged through the final count.
- R3: A legal write occupies exactly `cycle` clocks, numbered count 0 to count cycle-1. Count 0 is the first clock after the request is taken. `wr_done` is 1 during count cycle-1 only. If no new request is taken, the block returns to idle with all strobes high.
- R4: `mem_we_n` is 0 exactly in the counts k where we_setup <= k < we_setup + we_pulse.
- R5: Bit n of `mem_cs_n`, where n is the request's chip-select number, is 0 exactly in the counts k where cs_setup <= k < cs_setup + cs_pulse. All other bits stay 1.
- R6: A configuration write with `cfg_wr` high stores all six timing fields for the device `cfg_sel` only. Each device's writes use its own stored set, and storing a set for one device leaves the other devices unchanged.
- R7: A zero write pulse or zero chip-select pulse makes the request rejected. `cfg_err` is 1 for one clock, in count 0's position. No strobe falls, `wr_done` stays 0, and `mem_addr` keeps its previous value.
- R8: A cycle length smaller than setup + pulse of either strobe rejects the request as in R7.
- R9: With the edge-latch flag set, zero setup and zero hold on either strobe rejects the request as in R7. The same values with the flag clear run a normal write.
- R10: A back-to-back write to the same device with zero setup and zero hold keeps that strobe low across the cycle boundary with no high clock. With a nonzero setup, the strobe goes high for setup clocks in each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Store a timing set |
| cfg_sel | input | 2 | Device whose set is stored |
| cfg_we_setup | input | 6 | Write-strobe setup count |
| cfg_we_pulse | input | 6 | Write-strobe pulse count |
| cfg_cs_setup | input | 6 | Chip-select setup count |
| cfg_cs_pulse | input | 6 | Chip-select pulse count |
| cfg_cycle | input | 6 | Total cycle length in clocks |
| cfg_edge_latch | input | 1 | Device latches data on the strobe's rising edge |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request this clock |
| req_cs | input | 2 | Target device number |
| req_addr | input | 24 | Write address |
| req_data | input | 32 | Write data |
| mem_addr | output | 24 | Memory address bus |
| mem_data | output | 32 | Memory data bus |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_cs_n | output | 4 | Active-low chip selects, bit n for device n |
| wr_done | output | 1 | High during the final count of a write |
| cfg_err | output | 1 | One-clock pulse for a rejected request |

## Verification
The bench measures the count at which each strobe falls and rises against the programmed setup and pulse values. It uses several timing sets, including a 63-clock cycle. An off-by-one comparison would show up as a strobe edge one count early or late, or as a hold that is one clock short. The bench also covers zero pulse, a short cycle, and the edge-latch case with the flag set and with it clear. A checker that misses one of these cases would start strobing memory with an illegal timing set, and one that checks too much would reject the legal twin. Back-to-back writes with zero setup and zero hold are counted for high clocks. A design that adds an idle clock between writes, or that takes requests too early, shows a strobe gap or a cut-short cycle.

// File: rtl/swt_pkg.sv
package swt_pkg;
  localparam int TW = 6;
  typedef logic [TW-1:0] tick_t;

  typedef struct packed {
    tick_t we_setup;
    tick_t we_pulse;
    tick_t cs_setup;
    tick_t cs_pulse;
    tick_t cycle;
    logic  edge_latch;
  } tcfg_t;

  // True when count k lies in [s, s+p)
  function automatic logic in_win(tick_t k, tick_t s, tick_t p);
    logic [TW:0] lo, hi, kk;
    lo = {1'b0, s};
    hi = {1'b0, s} + {1'b0, p};
    kk = {1'b0, k};
    return (kk >= lo) && (kk < hi);
  endfunction
endpackage

// File: rtl/swt_cfg_bank.sv
module swt_cfg_bank
  import swt_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CSW-1:0] wr_sel,
  input  tcfg_t          wr_val,
  input  logic [CSW-1:0] rd_sel,
  output tcfg_t          rd_val
);
  tcfg_t bank [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[i] <= '0;
      else if (wr_en && wr_sel == CSW'(i))
        bank[i] <= wr_val;
    end
  end

  assign rd_val = bank[rd_sel];
endmodule

// File: rtl/swt_cfg_check.sv
module swt_cfg_check
  import swt_pkg::*;
(
  input  tcfg_t cfg,
  output logic  bad
);
  logic [TW:0] we_used, cs_used, cyc_w;
  logic        we_zero_p, cs_zero_p, we_short, cs_short, we_tight, cs_tight;

  always_comb begin
    we_used   = {1'b0, cfg.we_setup} + {1'b0, cfg.we_pulse};
    cs_used   = {1'b0, cfg.cs_setup} + {1'b0, cfg.cs_pulse};
    cyc_w     = {1'b0, cfg.cycle};
    we_zero_p = (cfg.we_pulse == '0);
    cs_zero_p = (cfg.cs_pulse == '0);
    we_short  = (cyc_w < we_used);
    cs_short  = (cyc_w < cs_used);
    // zero setup and zero hold leaves no edge margin for edge-latched parts
    we_tight  = cfg.edge_latch && (cfg.we_setup == '0) && (cyc_w == we_used);
    cs_tight  = cfg.edge_latch && (cfg.cs_setup == '0) && (cyc_w == cs_used);
    bad       = we_zero_p | cs_zero_p | we_short | cs_short | we_tight | cs_tight;
  end
endmodule

// File: rtl/swt_seq.sv
module swt_seq
  import swt_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int AW = 24,
  parameter int DW = 32,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  tcfg_t             sel_cfg,
  input  logic              sel_bad,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic              mem_we_n,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              wr_done,
  output logic              cfg_err
);
  localparam tick_t ONE = tick_t'(1);

  logic           busy;
  tick_t          cnt;
  tcfg_t          cur;
  logic [CSW-1:0] cur_cs;
  logic           last, take, we_on, cs_on;

  assign last      = busy && (cnt == cur.cycle - ONE);
  assign req_ready = !busy || last;
  assign take      = req_valid && req_ready;
  assign wr_done   = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cur      <= '0;
      cur_cs   <= '0;
      mem_addr <= '0;
      mem_data <= '0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= take && sel_bad;
      if (take && !sel_bad) begin
        busy     <= 1'b1;
        cnt      <= '0;
        cur      <= sel_cfg;
        cur_cs   <= req_cs;
        mem_addr <= req_addr;
        mem_data <= req_data;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + ONE;
      end
    end
  end

  assign we_on    = busy && in_win(cnt, cur.we_setup, cur.we_pulse);
  assign cs_on    = busy && in_win(cnt, cur.cs_setup, cur.cs_pulse);
  assign mem_we_n = !we_on;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csn
    assign mem_cs_n[i] = !(cs_on && cur_cs == CSW'(i));
  end

  // R2: bus fields frozen while a cycle runs
  a_r2_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(mem_addr) && $stable(mem_data)));
  // R3: counter steps by one through the cycle
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && cnt == tick_t'($past(cnt) + ONE)));
  // R3: count never reaches the programmed length
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < cur.cycle));
  // R5: at most one device selected
  a_r5_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  // R7: a rejected request never leaves a cycle running
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!busy && mem_we_n));
endmodule

// File: rtl/swt_write_timer.sv
module swt_write_timer
  import swt_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int AW = 24,
  parameter int DW = 32,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CSW-1:0]    cfg_sel,
  input  logic [TW-1:0]     cfg_we_setup,
  input  logic [TW-1:0]     cfg_we_pulse,
  input  logic [TW-1:0]     cfg_cs_setup,
  input  logic [TW-1:0]     cfg_cs_pulse,
  input  logic [TW-1:0]     cfg_cycle,
  input  logic              cfg_edge_latch,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic              mem_we_n,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              wr_done,
  output logic              cfg_err
);
  tcfg_t wr_val, sel_cfg;
  logic  sel_bad;

  assign wr_val = '{we_setup: cfg_we_setup, we_pulse: cfg_we_pulse,
                    cs_setup: cfg_cs_setup, cs_pulse: cfg_cs_pulse,
                    cycle: cfg_cycle, edge_latch: cfg_edge_latch};

  swt_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_sel(cfg_sel),
    .wr_val(wr_val), .rd_sel(req_cs), .rd_val(sel_cfg)
  );

  swt_cfg_check u_check (.cfg(sel_cfg), .bad(sel_bad));

  swt_seq #(.NUM_CS(NUM_CS), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .req_addr(req_addr), .req_data(req_data),
    .sel_cfg(sel_cfg), .sel_bad(sel_bad), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_we_n(mem_we_n), .mem_cs_n(mem_cs_n),
    .wr_done(wr_done), .cfg_err(cfg_err)
  );
endmodule

// File: tb/sim_swt_write_timer.sv
module sim_swt_write_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [5:0]  cfg_we_setup = '0, cfg_we_pulse = '0, cfg_cs_setup = '0;
  logic [5:0]  cfg_cs_pulse = '0, cfg_cycle = '0;
  logic        cfg_edge_latch = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cs = '0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        req_ready, mem_we_n, wr_done, cfg_err;
  logic [23:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_cs_n;

  swt_write_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_we_setup(cfg_we_setup), .cfg_we_pulse(cfg_we_pulse),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse),
    .cfg_cycle(cfg_cycle), .cfg_edge_latch(cfg_edge_latch),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_addr(req_addr), .req_data(req_data), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_we_n(mem_we_n), .mem_cs_n(mem_cs_n),
    .wr_done(wr_done), .cfg_err(cfg_err)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [1:0] cs;
    logic [5:0] ws, wp, css, csp, cyc;
    logic       edg, bad;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 6'd1, 6'd2, 6'd0, 6'd4, 6'd5,  1'b0, 1'b0},
    '{2'd1, 6'd0, 6'd3, 6'd0, 6'd3, 6'd3,  1'b0, 1'b0},
    '{2'd2, 6'd2, 6'd1, 6'd1, 6'd3, 6'd6,  1'b1, 1'b0},
    '{2'd3, 6'd0, 6'd1, 6'd1, 6'd1, 6'd2,  1'b1, 1'b0},
    '{2'd0, 6'd1, 6'd0, 6'd0, 6'd2, 6'd3,  1'b0, 1'b1},  // R7 zero write pulse
    '{2'd1, 6'd1, 6'd1, 6'd0, 6'd1, 6'd1,  1'b0, 1'b1},  // R8 cycle too short
    '{2'd2, 6'd0, 6'd2, 6'd1, 6'd1, 6'd2,  1'b1, 1'b1},  // R9 edge-latched, no margin
    '{2'd3, 6'd0, 6'd2, 6'd1, 6'd1, 6'd2,  1'b0, 1'b0},  // R9 same values, flag clear
    '{2'd0, 6'd0, 6'd1, 6'd10, 6'd20, 6'd63, 1'b0, 1'b0}
  };

  int n_chk = 0, n_bad = 0;
  int m_ws[4], m_wp[4], m_css[4], m_csp[4], m_cyc[4];
  int we_hi = 0, cs_hi = 0;
  logic [23:0] last_addr = '0;

  task automatic chk(string rq, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic prog(int cs, int ws, int wp, int css, int csp, int cyc, bit edg);
    cfg_sel = 2'(cs); cfg_we_setup = 6'(ws); cfg_we_pulse = 6'(wp);
    cfg_cs_setup = 6'(css); cfg_cs_pulse = 6'(csp); cfg_cycle = 6'(cyc);
    cfg_edge_latch = edg; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_ws[cs] = ws; m_wp[cs] = wp; m_css[cs] = css; m_csp[cs] = csp; m_cyc[cs] = cyc;
  endtask

  // Starts at a negedge with req_ready expected high; a good write ends at
  // the negedge of its final count, a rejected one at the following idle negedge.
  task automatic do_write(int cs, logic [23:0] a, logic [31:0] d, bit bad);
    int ws = m_ws[cs], wp = m_wp[cs], css = m_css[cs], csp = m_csp[cs], cyc = m_cyc[cs];
    req_valid = 1'b1; req_cs = 2'(cs); req_addr = a; req_data = d;
    chk("R2 ready before take", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk("R7 err pulse", cfg_err, 1);
      chk("R7 no write strobe", mem_we_n, 1);
      chk("R7 no chip select", mem_cs_n, 4'hF);
      chk("R7 no done", wr_done, 0);
      chk("R7 address kept", mem_addr, last_addr);
      @(negedge clk);
      chk("R7 err one clock", cfg_err, 0);
      chk("R7 still idle", mem_we_n, 1);
    end else begin
      last_addr = a;
      for (int k = 0; k < cyc; k++) begin
        logic [3:0] ecs;
        ecs = 4'hF;
        if (k >= css && k < css + csp) ecs[cs] = 1'b0;
        chk("R4 write strobe", mem_we_n, (k >= ws && k < ws + wp) ? 0 : 1);
        chk("R5 chip select", mem_cs_n, ecs);
        chk("R3 done position", wr_done, (k == cyc - 1) ? 1 : 0);
        chk("R2 ready position", req_ready, (k == cyc - 1) ? 1 : 0);
        chk("R2 address held", mem_addr, a);
        chk("R2 data held", mem_data, d);
        if (mem_we_n) we_hi++;
        if (mem_cs_n[cs]) cs_hi++;
        if (k != cyc - 1) @(negedge clk);
      end
    end
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R3 idle write strobe", mem_we_n, 1);
    chk("R3 idle chip selects", mem_cs_n, 4'hF);
    chk("R3 idle done", wr_done, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 cs_n", mem_cs_n, 4'hF);
    chk("R1 done", wr_done, 0);
    chk("R1 err", cfg_err, 0);
    chk("R1 ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", mem_we_n, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v = TBL[i];
      prog(int'(v.cs), int'(v.ws), int'(v.wp), int'(v.css), int'(v.csp), int'(v.cyc), v.edg);
      do_write(int'(v.cs), 24'h100 + 24'(i), 32'hA5000000 | 32'(i), v.bad);
      if (!v.bad) idle_chk();
    end

    // R6: separate sets per device
    prog(0, 1, 2, 0, 4, 5, 1'b0);
    prog(1, 0, 1, 0, 1, 1, 1'b0);
    do_write(0, 24'h0A0A0A, 32'h11111111, 1'b0);
    idle_chk();
    do_write(1, 24'h0B0B0B, 32'h22222222, 1'b0);
    idle_chk();
    prog(1, 3, 3, 0, 6, 6, 1'b0);
    we_hi = 0;
    do_write(0, 24'h0C0C0C, 32'h33333333, 1'b0);
    chk("R6 device 0 set unchanged", we_hi, 3);
    idle_chk();

    // R10: zero setup and hold, back-to-back
    prog(1, 0, 4, 0, 4, 4, 1'b0);
    we_hi = 0; cs_hi = 0;
    do_write(1, 24'h000010, 32'hCAFE0001, 1'b0);
    do_write(1, 24'h000014, 32'hCAFE0002, 1'b0);
    chk("R10 write strobe no gap", we_hi, 0);
    chk("R10 chip select no gap", cs_hi, 0);
    idle_chk();

    // R10: nonzero setup returns high each write
    prog(2, 1, 2, 1, 2, 3, 1'b0);
    we_hi = 0; cs_hi = 0;
    do_write(2, 24'h000020, 32'hBEEF0001, 1'b0);
    do_write(2, 24'h000024, 32'hBEEF0002, 1'b0);
    chk("R10 write strobe setup gaps", we_hi, 2);
    chk("R10 chip select setup gaps", cs_hi, 2);
    idle_chk();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule